// File: doc/BRIEF.md
# Parallel-Port Register Access Sequencer

This block sits on the host side of a parallel-port link to an IDE bridge. It turns one register access into the fixed series of data-port and control-port writes that the bridge decodes. It also performs the link open and link close sequences. Each port write is one step, and every step stays on the port for a programmable number of clock cycles. On a read, the bridge answers through the status port in two nibbles. The block samples both nibbles and joins them into one byte.

A link open first records whatever the data and control ports held before. A link close later puts those values back. Accesses are taken through a valid/ready handshake. Each access carries a direction, a one-bit bank select, a three-bit register index and a write byte. Read results come back with a one-cycle valid pulse. An access offered while the link is closed is consumed and flagged, and nothing else happens.

Top module: `ppseq_top`

## Requirements
- R1: After reset: pd_out = 0x00, pc_out = 0x4, req_ready = 1, rsp_valid = 0, err_pulse = 0, link_up = 0, and the step hold setting is 2.
- R2: A link open (conn_req while link_up = 0 and idle) captures pd_in and pc_in, writes control 0x4 as its only step, and sets link_up when that step ends.
- R3: Every access starts with an address phase of nine steps: control 0x4; data = selector; then control 0xC, 0xE, 0xE, 0xC, 0x4, 0x4, 0x4. The selector is 0x08 plus the index when req_set = 0, and 0x10 plus the index when req_set = 1.
- R4: After the address phase, a read writes control 0x6, then 0x4, then 0x4 again. The low status byte is sampled in the 0x6 step and the high status byte in the first 0x4 step.
- R5: Read data is {high_status[7:4], low_status[7:4]}, with the low sample's upper nibble placed in bits 3:0.
- R6: After the address phase, a write puts req_wdata on the data port and then writes control 0x5, 0x7, 0x5, 0x4.
- R7: Each step's port value holds for hold+1 clock cycles. cfg_we loads cfg_hold into the hold setting only while the block is idle. While a sequence runs, cfg_we has no effect on that sequence or on later ones.
- R8: rsp_valid is high for exactly one cycle, in the cycle after a read's last step ends. Writes produce no rsp_valid.
- R9: A link close (disc_req while link_up = 1 and idle) runs the address phase with selector 0x20. It then writes the captured data value and the captured control value as its last two steps, and clears link_up.
- R10: An access accepted while link_up = 0 pulses err_pulse for one cycle and changes neither port nor rsp_valid.
- R11: req_ready is low while a sequence runs. conn_req while the link is up, and disc_req while it is down, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load hold setting (idle only) |
| cfg_hold | input | HOLD_W | New hold setting |
| conn_req | input | 1 | Open the link |
| disc_req | input | 1 | Close the link |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Access request accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_set | input | 1 | Register bank select |
| req_idx | input | 3 | Register index |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_data | output | 8 | Read data |
| err_pulse | output | 1 | Access attempted with link closed |
| link_up | output | 1 | Link open state |
| pd_out | output | 8 | Data port value |
| pd_in | input | 8 | Data port prior value |
| pc_out | output | 4 | Control port value |
| pc_in | input | 4 | Control port prior value |
| status_in | input | 8 | Status port |

## Verification
The hardest case to reach is a hold-setting write that arrives in the middle of a running sequence. The change has to be refused, and the refusal only shows as step lengths that stay the same. The stimulus fires cfg_we partway through one access. It then compares every cycle of that trace, and of the next access, against the old hold value. The status model returns different bytes for control 0x6 and for other control values. This means a nibble swap or a sample taken in the wrong step changes the returned byte. The random accesses also vary the hold from 0 to 3, so the step boundaries move.

// File: rtl/ppseq_pkg.sv
package ppseq_pkg;

    localparam int STEP_W = 4;

    typedef enum logic [1:0] {
        OP_CONN = 2'd0,
        OP_DISC = 2'd1,
        OP_RD   = 2'd2,
        OP_WR   = 2'd3
    } op_e;

    // One port write: either the data port or the control port (val[3:0])
    typedef struct packed {
        logic       to_data;
        logic [7:0] val;
    } step_t;

    function automatic logic [STEP_W-1:0] last_step(input op_e op);
        case (op)
            OP_CONN: last_step = STEP_W'(0);
            OP_DISC: last_step = STEP_W'(10);
            OP_RD:   last_step = STEP_W'(11);
            default: last_step = STEP_W'(13);
        endcase
    endfunction

endpackage

// File: rtl/ppseq_step_table.sv
module ppseq_step_table
    import ppseq_pkg::*;
(
    input  op_e              op,
    input  logic [STEP_W-1:0] idx,
    input  logic [7:0]       sel,
    input  logic [7:0]       wdata,
    input  logic [7:0]       sv_pd,
    input  logic [3:0]       sv_pc,
    output step_t            st
);

    localparam logic [7:0] C_IDLE = 8'h04;

    always_comb begin
        st.to_data = 1'b0;
        st.val     = C_IDLE;
        if (op != OP_CONN) begin
            if (idx <= STEP_W'(8)) begin
                // address phase: latch pulse pattern around the selector
                case (idx)
                    STEP_W'(1): begin st.to_data = 1'b1; st.val = sel; end
                    STEP_W'(2): st.val = 8'h0C;
                    STEP_W'(3): st.val = 8'h0E;
                    STEP_W'(4): st.val = 8'h0E;
                    STEP_W'(5): st.val = 8'h0C;
                    default:    st.val = C_IDLE;
                endcase
            end else begin
                case (op)
                    OP_RD: begin
                        if (idx == STEP_W'(9)) st.val = 8'h06;
                    end
                    OP_WR: begin
                        case (idx)
                            STEP_W'(9):  begin st.to_data = 1'b1; st.val = wdata; end
                            STEP_W'(10): st.val = 8'h05;
                            STEP_W'(11): st.val = 8'h07;
                            STEP_W'(12): st.val = 8'h05;
                            default:     st.val = C_IDLE;
                        endcase
                    end
                    default: begin
                        if (idx == STEP_W'(9)) begin
                            st.to_data = 1'b1;
                            st.val     = sv_pd;
                        end else begin
                            st.val = {4'h0, sv_pc};
                        end
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/ppseq_hold_timer.sv
module ppseq_hold_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         expire
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart)  cnt_d = '0;
        else if (run) cnt_d = cnt_q + W'(1);
    end

    assign expire = run && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/ppseq_top.sv
module ppseq_top
    import ppseq_pkg::*;
#(
    parameter int HOLD_W   = 4,
    parameter int HOLD_RST = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [HOLD_W-1:0] cfg_hold,
    input  logic              conn_req,
    input  logic              disc_req,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_set,
    input  logic [2:0]        req_idx,
    input  logic [7:0]        req_wdata,
    output logic              rsp_valid,
    output logic [7:0]        rsp_data,
    output logic              err_pulse,
    output logic              link_up,
    output logic [7:0]        pd_out,
    input  logic [7:0]        pd_in,
    output logic [3:0]        pc_out,
    input  logic [3:0]        pc_in,
    input  logic [7:0]        status_in
);

    localparam logic [7:0]        SEL_CLOSE = 8'h20;
    localparam logic [STEP_W-1:0] RD_LO_STEP = STEP_W'(9);
    localparam logic [STEP_W-1:0] RD_HI_STEP = STEP_W'(10);

    typedef struct packed {
        logic              busy;
        op_e               op;
        logic [STEP_W-1:0] step;
        logic [7:0]        sel;
        logic [7:0]        wd;
        logic [7:0]        sv_pd;
        logic [3:0]        sv_pc;
        logic              conn;
        logic [7:0]        pd;
        logic [3:0]        pc;
        logic [3:0]        lo;
        logic              rsp_v;
        logic [7:0]        rsp_d;
        logic              err;
        logic [HOLD_W-1:0] hold;
    } regs_t;

    regs_t q, n;

    logic              conn_go, disc_go, req_go, go, expire, at_last, advance;
    op_e               in_op, tbl_op;
    logic [STEP_W-1:0] tbl_idx;
    logic [7:0]        in_sel;
    step_t             st;

    // request arbitration: link control takes precedence over accesses
    always_comb begin
        conn_go   = !q.busy && conn_req && !q.conn;
        disc_go   = !q.busy && !conn_go && disc_req && q.conn;
        req_ready = !q.busy && !conn_go && !disc_go;
        req_go    = req_ready && req_valid;
        go        = conn_go || disc_go || (req_go && q.conn);
        if (conn_go)        in_op = OP_CONN;
        else if (disc_go)   in_op = OP_DISC;
        else if (req_write) in_op = OP_WR;
        else                in_op = OP_RD;
        in_sel  = disc_go ? SEL_CLOSE : {3'b000, req_set, ~req_set, req_idx};
        at_last = (q.step == last_step(q.op));
        advance = q.busy && expire && !at_last;
        tbl_op  = q.busy ? q.op : in_op;
        tbl_idx = q.busy ? q.step + STEP_W'(1) : '0;
    end

    ppseq_step_table u_tbl (
        .op    (tbl_op),
        .idx   (tbl_idx),
        .sel   (q.sel),
        .wdata (q.wd),
        .sv_pd (q.sv_pd),
        .sv_pc (q.sv_pc),
        .st    (st)
    );

    ppseq_hold_timer #(.W(HOLD_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (go || advance),
        .run     (q.busy),
        .limit   (q.hold),
        .expire  (expire)
    );

    always_comb begin
        n       = q;
        n.rsp_v = 1'b0;
        n.err   = 1'b0;

        if (!q.busy && cfg_we) n.hold = cfg_hold;

        if (req_go && !q.conn) n.err = 1'b1;

        if (go) begin
            n.busy = 1'b1;
            n.op   = in_op;
            n.step = '0;
            n.sel  = in_sel;
            n.wd   = req_wdata;
            if (conn_go) begin
                n.sv_pd = pd_in;
                n.sv_pc = pc_in;
            end
        end

        if (q.busy && expire) begin
            if (q.op == OP_RD && q.step == RD_LO_STEP) n.lo = status_in[7:4];
            if (q.op == OP_RD && q.step == RD_HI_STEP) n.rsp_d = {status_in[7:4], q.lo};
            if (at_last) begin
                n.busy = 1'b0;
                case (q.op)
                    OP_CONN: n.conn  = 1'b1;
                    OP_DISC: n.conn  = 1'b0;
                    OP_RD:   n.rsp_v = 1'b1;
                    default: ;
                endcase
            end else begin
                n.step = q.step + STEP_W'(1);
            end
        end

        if (go || advance) begin
            if (st.to_data) n.pd = st.val;
            else            n.pc = st.val[3:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.pc   <= 4'h4;
            q.hold <= HOLD_W'(HOLD_RST);
        end else begin
            q <= n;
        end
    end

    assign rsp_valid = q.rsp_v;
    assign rsp_data  = q.rsp_d;
    assign err_pulse = q.err;
    assign link_up   = q.conn;
    assign pd_out    = q.pd;
    assign pc_out    = q.pc;

endmodule

// File: rtl/ppseq_checker.sv
module ppseq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       rsp_valid,
    input logic       err_pulse,
    input logic       link_up,
    input logic [7:0] pd_out,
    input logic [3:0] pc_out
);

    // R8: response is a single-cycle pulse
    a_r8_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R4: a read ends with the control port back at 0x4
    a_r4_rsp_ctl_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> pc_out == 4'h4);

    // R10: an access while the link is closed is flagged
    a_r10_err_when_down: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !link_up) |=> err_pulse);

    // R10: a flagged access touches no port and gives no response
    a_r10_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> ($stable(pd_out) && $stable(pc_out) && !rsp_valid));

    // R11: an accepted access makes the block busy
    a_r11_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && link_up) |=> !req_ready);

endmodule

bind ppseq_top ppseq_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .err_pulse (err_pulse),
    .link_up   (link_up),
    .pd_out    (pd_out),
    .pc_out    (pc_out)
);

// File: tb/sim_ppseq_top.sv
`timescale 1ns/1ps
module sim_ppseq_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_hold = 4'h0;
    logic       conn_req = 1'b0, disc_req = 1'b0;
    logic       req_valid = 1'b0, req_write = 1'b0, req_set = 1'b0;
    logic [2:0] req_idx = 3'h0;
    logic [7:0] req_wdata = 8'h00;
    logic       req_ready, rsp_valid, err_pulse, link_up;
    logic [7:0] rsp_data, pd_out, status_in;
    logic [3:0] pc_out;
    logic [7:0] pd_in = 8'h3C;
    logic [3:0] pc_in = 4'hB;
    logic [7:0] st_lo = 8'h00, st_hi = 8'h00;

    int checks = 0, fails = 0;
    int cur_hold = 2;
    logic [7:0] ex_pd = 8'h00, sv_pd = 8'h00;
    logic [3:0] ex_pc = 4'h4, sv_pc = 4'h0;

    always #5 clk = ~clk;

    assign status_in = (pc_out == 4'h6) ? st_lo : st_hi;

    ppseq_top u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_hold(cfg_hold),
        .conn_req(conn_req), .disc_req(disc_req), .req_valid(req_valid),
        .req_ready(req_ready), .req_write(req_write), .req_set(req_set),
        .req_idx(req_idx), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .err_pulse(err_pulse), .link_up(link_up),
        .pd_out(pd_out), .pd_in(pd_in), .pc_out(pc_out), .pc_in(pc_in),
        .status_in(status_in)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s got=0x%0h exp=0x%0h", req, got, exp);
        end
    endtask

    // kinds: 0 open, 1 close, 2 read, 3 write
    function automatic int nsteps(input int kind);
        case (kind)
            0: nsteps = 1;
            1: nsteps = 11;
            2: nsteps = 12;
            default: nsteps = 14;
        endcase
    endfunction

    function automatic logic [8:0] exp_step(input int kind, input int k, input logic [7:0] sel,
                                            input logic [7:0] wd);
        logic [3:0] addr_ctl [0:8];
        addr_ctl = '{4'h4, 4'h0, 4'hC, 4'hE, 4'hE, 4'hC, 4'h4, 4'h4, 4'h4};
        if (kind == 0) return {1'b0, 8'h04};
        if (k == 1) return {1'b1, sel};
        if (k <= 8) return {1'b0, 4'h0, addr_ctl[k]};
        if (kind == 2) return {1'b0, (k == 9) ? 8'h06 : 8'h04};
        if (kind == 3) begin
            case (k)
                9: return {1'b1, wd};
                10: return {1'b0, 8'h05};
                11: return {1'b0, 8'h07};
                12: return {1'b0, 8'h05};
                default: return {1'b0, 8'h04};
            endcase
        end
        if (k == 9) return {1'b1, sv_pd};
        return {1'b0, 4'h0, sv_pc};
    endfunction

    task automatic set_hold(input int v);
        cfg_we = 1'b1; cfg_hold = 4'(v);
        @(negedge clk);
        cfg_we = 1'b0;
        cur_hold = v;
    endtask

    // called right after a negedge; returns right after a negedge
    task automatic run_op(input int kind, input bit set, input logic [2:0] idx,
                          input logic [7:0] wd, input bit poke, input string tag);
        logic [7:0] sel;
        logic [8:0] e;
        bit bad = 0;
        logic [11:0] got_bad = '0, exp_bad = '0;
        sel = (kind == 1) ? 8'h20 : ((set ? 8'h10 : 8'h08) | {5'b0, idx});
        if (kind == 0) begin sv_pd = pd_in; sv_pc = pc_in; conn_req = 1'b1; end
        else if (kind == 1) disc_req = 1'b1;
        else begin
            req_valid = 1'b1; req_write = (kind == 3); req_set = set;
            req_idx = idx; req_wdata = wd;
        end
        for (int k = 0; k < nsteps(kind); k++) begin
            for (int c = 0; c <= cur_hold; c++) begin
                @(negedge clk);
                cfg_we = 1'b0;
                if (k == 0 && c == 0) begin
                    conn_req = 1'b0; disc_req = 1'b0; req_valid = 1'b0;
                    chk(req_ready == 1'b0, "R11 ready low while busy", 32'(req_ready), 0);
                end
                if (c == 0) begin
                    e = exp_step(kind, k, sel, wd);
                    if (e[8]) ex_pd = e[7:0]; else ex_pc = e[3:0];
                end
                if (!bad && (pd_out != ex_pd || pc_out != ex_pc)) begin
                    bad = 1; got_bad = {pd_out, pc_out}; exp_bad = {ex_pd, ex_pc};
                end
                if (poke && k == 3 && c == 0) begin cfg_we = 1'b1; cfg_hold = 4'h7; end
            end
        end
        chk(!bad, {tag, " port trace R3 R7"}, 32'(got_bad), 32'(exp_bad));
        @(negedge clk);
        cfg_we = 1'b0;
        if (kind == 2) begin
            chk(rsp_valid == 1'b1, "R8 rsp_valid after read", 32'(rsp_valid), 1);
            chk(rsp_data == {st_hi[7:4], st_lo[7:4]}, {tag, " R5 read data"},
                32'(rsp_data), 32'({st_hi[7:4], st_lo[7:4]}));
        end else begin
            chk(rsp_valid == 1'b0, "R8 no rsp for non-read", 32'(rsp_valid), 0);
        end
        if (kind == 0) chk(link_up == 1'b1, "R2 link up after open", 32'(link_up), 1);
        if (kind == 1) chk(link_up == 1'b0, "R9 link down after close", 32'(link_up), 0);
        chk(req_ready == 1'b1, "R11 ready after sequence", 32'(req_ready), 1);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R8 rsp single pulse", 32'(rsp_valid), 0);
    endtask

    task automatic try_down_access;
        req_valid = 1'b1; req_write = 1'b1; req_wdata = 8'h99;
        @(negedge clk);
        req_valid = 1'b0;
        chk(err_pulse == 1'b1, "R10 err pulse", 32'(err_pulse), 1);
        chk(pd_out == ex_pd && pc_out == ex_pc, "R10 ports unchanged",
            32'({pd_out, pc_out}), 32'({ex_pd, ex_pc}));
        chk(rsp_valid == 1'b0, "R10 no rsp", 32'(rsp_valid), 0);
        @(negedge clk);
        chk(err_pulse == 1'b0, "R10 err single pulse", 32'(err_pulse), 0);
        chk(pd_out == ex_pd && pc_out == ex_pc, "R10 ports still unchanged",
            32'({pd_out, pc_out}), 32'({ex_pd, ex_pc}));
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired got=0 exp=1");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(pd_out == 8'h00, "R1 pd_out reset", 32'(pd_out), 0);
        chk(pc_out == 4'h4, "R1 pc_out reset", 32'(pc_out), 4);
        chk(req_ready && !rsp_valid && !err_pulse && !link_up, "R1 status reset",
            32'({req_ready, rsp_valid, err_pulse, link_up}), 32'h8);

        // R10 and R11: access and close while the link is down
        try_down_access();
        disc_req = 1'b1;
        @(negedge clk);
        disc_req = 1'b0;
        @(negedge clk);
        chk(pd_out == ex_pd && pc_out == ex_pc && !link_up, "R11 close while down ignored",
            32'({link_up, pd_out, pc_out}), 32'({1'b0, ex_pd, ex_pc}));

        // R2 open using the default hold of 2 (R1, R7)
        run_op(0, 0, 3'h0, 8'h00, 0, "R2 open");
        conn_req = 1'b1;
        @(negedge clk);
        conn_req = 1'b0;
        chk(req_ready == 1'b1 && pd_out == ex_pd && pc_out == ex_pc, "R11 open while up ignored",
            32'({req_ready, pd_out, pc_out}), 32'({1'b1, ex_pd, ex_pc}));

        // directed accesses
        st_lo = 8'hA5; st_hi = 8'h3C;
        run_op(2, 0, 3'h0, 8'h00, 0, "R4 read set0 idx0");
        st_lo = 8'h0F; st_hi = 8'hF0;
        run_op(2, 1, 3'h7, 8'h00, 0, "R4 read set1 idx7");
        run_op(3, 0, 3'h5, 8'hA5, 0, "R6 write set0 idx5");
        run_op(3, 1, 3'h2, 8'h00, 0, "R6 write zero byte");
        set_hold(0);
        st_lo = 8'h12; st_hi = 8'h34;
        run_op(2, 1, 3'h3, 8'h00, 0, "R7 read hold0");
        set_hold(3);
        run_op(3, 0, 3'h1, 8'hFF, 0, "R7 write hold3");
        // R7: cfg_we mid-sequence is ignored for this and the next op
        set_hold(1);
        st_lo = 8'hE7; st_hi = 8'h5B;
        run_op(2, 0, 3'h6, 8'h00, 1, "R7 busy cfg ignored");
        run_op(3, 1, 3'h4, 8'h66, 0, "R7 after busy cfg");

        // random accesses
        for (int i = 0; i < 40; i++) begin
            if (i % 8 == 0) set_hold($urandom_range(0, 3));
            st_lo = 8'($urandom); st_hi = 8'($urandom);
            run_op($urandom_range(2, 3), 1'($urandom), 3'($urandom), 8'($urandom), 0, "rand op");
        end

        // R9 close restores captured values
        set_hold(2);
        pd_in = 8'h00; pc_in = 4'h0;
        run_op(1, 0, 3'h0, 8'h00, 0, "R9 close");
        chk(pd_out == 8'h3C && pc_out == 4'hB, "R9 restored ports",
            32'({pd_out, pc_out}), 32'h3CB);
        try_down_access();

        // second open captures new values
        pd_in = 8'h81; pc_in = 4'h2;
        run_op(0, 0, 3'h0, 8'h00, 0, "R2 reopen");
        run_op(1, 0, 3'h0, 8'h00, 0, "R9 close again");
        chk(pd_out == 8'h81 && pc_out == 4'h2, "R2 R9 new capture restored",
            32'({pd_out, pc_out}), 32'h812);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule